// File: doc/BRIEF.md
# Configuration and Start-Up Sequencer

This block is the controller that walks a programmable device from power-up to running logic. After a power-on delay it clears the configuration memory, waits for the shared open-drain INIT line to read high, lets an external loader bring in the configuration data, and then runs a start-up sequence. That sequence raises DONE, then drops the global output-disable hold, then drops the global set/reset and write-enable holds together. A program request that is held low for long enough restarts the whole flow from the clear phase, at any point in the flow.

The INIT line is shared. The block pulls it low during power-up and memory clearing. An outside agent may keep it low after that to delay loading, and the sequencer waits until the line is sensed high. The mode pins are captured when clearing ends and choose whether the loader takes its data from the scan path or from the normal port. The loader is modelled only as an enable out (`loadEn`) and a done flag in (`loadDone`).

Top module: `cfg_startup_seq`

## Requirements
- R1: After `porRst` is released, the block stays in a power-up phase for exactly POR_CYCLES clock cycles. In that phase `initDriveLow`=1, `clearMem`=0, `loadEn`=0, `doneOut`=0 and `gtsHold`=`gsrHold`=`gweHold`=1. The same values apply while `porRst`=1.
- R2: The clear phase holds `clearMem`=1 and `initDriveLow`=1 for exactly CLEAR_CYCLES cycles. After that both are 0.
- R3: The phases always run in the order clear, INIT wait, load, start-up. `loadEn`=1 only in the load phase. `doneOut` stays 0 while loading continues without `loadDone`.
- R4: After clearing, while the sensed `initIn` is 0 (held low from outside), `loadEn` stays 0. `loadEn` becomes 1 one cycle after `initIn` is sampled high.
- R5: `doneOut` rises one cycle after `loadDone`=1 is sampled in the load phase. In that first cycle all three holds are still 1.
- R6: `gtsHold` falls exactly one cycle after `doneOut` rises. `gsrHold` is still 1 in that cycle.
- R7: `gsrHold` and `gweHold` fall together exactly one cycle after `gtsHold` falls.
- R8: `scanSelect` is 1 when `modeSel` (bit 2 = M2, bit 1 = M1, bit 0 = M0) equals 3'b101 or 3'b001 at the last clear cycle, and 0 otherwise. It keeps that value until the next end of clearing.
- R9: A program request is accepted only after `progReqN` has been sampled low on PROG_MIN consecutive clock edges. A shorter low pulse has no effect.
- R10: An accepted request aborts any phase, including after DONE. On the next cycle the block is in the clear phase with `doneOut`=0 and all holds at 1. Clearing restarts for as long as the request stays held.
- R11: `loadDone` outside the load phase is ignored and does not raise `doneOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| porRst | input | 1 | Power-on reset, active high |
| progReqN | input | 1 | Program request, active low |
| initIn | input | 1 | Sensed level of the shared open-drain INIT line |
| modeSel | input | 3 | Mode pins {M2,M1,M0} |
| loadDone | input | 1 | Loader reports all data loaded |
| initDriveLow | output | 1 | Pull the INIT line low |
| clearMem | output | 1 | Configuration memory clear active |
| loadEn | output | 1 | Loader enable (load phase) |
| scanSelect | output | 1 | Loader takes data from the scan path |
| doneOut | output | 1 | Configuration complete |
| gtsHold | output | 1 | Global output 3-state hold |
| gsrHold | output | 1 | Global set/reset hold |
| gweHold | output | 1 | Global write-enable hold |

## Verification
Every output is decoded from the phase register, so a wrong phase or wrong counter appears at the ports on the very next cycle. A clear phase that is one cycle short or long moves the fall of `clearMem`. A skipped INIT wait raises `loadEn` while the line is still held low. A start-up step that is merged or reordered makes `gtsHold` and `gsrHold` fall on the same edge. A wrong program filter count makes `doneOut` fall after a pulse one cycle too short, or stay high after a pulse that is long enough. A cycle-by-cycle reference in the bench compares all eight outputs on every cycle, under directed corner cases and random request bursts, INIT holds and loader timing.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  typedef enum logic [2:0] {
    PH_POWERUP  = 3'd0,
    PH_CLEAR    = 3'd1,
    PH_INITWAIT = 3'd2,
    PH_LOAD     = 3'd3,
    PH_DONE     = 3'd4,
    PH_GTSOFF   = 3'd5,
    PH_RUN      = 3'd6
  } phase_t;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic cntZero;
    logic cntStep;
    logic modeCapture;
  } dpCtl_t;

  function automatic logic isScanMode(input logic [2:0] pins);
    return (pins == 3'b101) || (pins == 3'b001);
  endfunction

endpackage

// File: rtl/cfg_seq_dpath.sv
module cfg_seq_dpath
  import cfg_seq_pkg::*;
#(
  parameter int POR_CYCLES   = 1000,
  parameter int CLEAR_CYCLES = 256,
  parameter int PROG_MIN     = 4
) (
  input  logic        clk,
  input  logic        porRst,
  input  logic        progReqN,
  input  logic [2:0]  modeSel,
  input  dpCtl_t      ctl,
  output logic        hitPor,
  output logic        hitClear,
  output logic        progAccept,
  output logic        scanSel
);

  localparam int CNT_MAX = (POR_CYCLES > CLEAR_CYCLES) ? POR_CYCLES : CLEAR_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int PROG_W  = $clog2(PROG_MIN + 1);
  localparam logic [CNT_W-1:0]  POR_LAST   = CNT_W'(POR_CYCLES - 1);
  localparam logic [CNT_W-1:0]  CLEAR_LAST = CNT_W'(CLEAR_CYCLES - 1);
  localparam logic [PROG_W-1:0] PROG_FULL  = PROG_W'(PROG_MIN);

  logic [CNT_W-1:0]  phaseCnt;
  logic [PROG_W-1:0] progCnt;

  // shared phase-length counter
  always_ff @(posedge clk) begin
    if (porRst)              phaseCnt <= '0;
    else if (ctl.cntZero)    phaseCnt <= '0;
    else if (ctl.cntStep)    phaseCnt <= phaseCnt + 1'b1;
  end

  assign hitPor   = (phaseCnt == POR_LAST);
  assign hitClear = (phaseCnt == CLEAR_LAST);

  // program request width filter, saturating
  always_ff @(posedge clk) begin
    if (porRst)               progCnt <= '0;
    else if (progReqN)        progCnt <= '0;
    else if (progCnt != PROG_FULL) progCnt <= progCnt + 1'b1;
  end

  assign progAccept = (progCnt == PROG_FULL);

  // mode capture at end of clearing
  always_ff @(posedge clk) begin
    if (porRst)               scanSel <= 1'b0;
    else if (ctl.modeCapture) scanSel <= isScanMode(modeSel);
  end

  AST_PROG_AFTER_LOW: assert property (@(posedge clk) disable iff (porRst)
    progAccept |-> $past(!progReqN)); // R9

  AST_SCAN_HELD: assert property (@(posedge clk) disable iff (porRst)
    !ctl.modeCapture |=> $stable(scanSel)); // R8

endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import cfg_seq_pkg::*;
(
  input  logic   clk,
  input  logic   porRst,
  input  logic   hitPor,
  input  logic   hitClear,
  input  logic   progAccept,
  input  logic   initIn,
  input  logic   loadDone,
  output dpCtl_t ctl,
  output logic   initDriveLow,
  output logic   clearMem,
  output logic   loadEn,
  output logic   doneOut,
  output logic   gtsHold,
  output logic   gsrHold,
  output logic   gweHold
);

  phase_t phase, phaseNxt;

  always_ff @(posedge clk) begin
    if (porRst) phase <= PH_POWERUP;
    else        phase <= phaseNxt;
  end

  always_comb begin
    phaseNxt = phase;
    ctl      = '0;
    if (progAccept) begin
      phaseNxt    = PH_CLEAR;
      ctl.cntZero = 1'b1;
    end else begin
      unique case (phase)
        PH_POWERUP: begin
          if (hitPor) begin
            phaseNxt    = PH_CLEAR;
            ctl.cntZero = 1'b1;
          end else begin
            ctl.cntStep = 1'b1;
          end
        end
        PH_CLEAR: begin
          if (hitClear) begin
            phaseNxt        = PH_INITWAIT;
            ctl.modeCapture = 1'b1;
          end else begin
            ctl.cntStep = 1'b1;
          end
        end
        PH_INITWAIT: if (initIn) phaseNxt = PH_LOAD;
        PH_LOAD:     if (loadDone) phaseNxt = PH_DONE;
        PH_DONE:     phaseNxt = PH_GTSOFF;
        PH_GTSOFF:   phaseNxt = PH_RUN;
        PH_RUN:      phaseNxt = PH_RUN;
        default:     phaseNxt = PH_POWERUP;
      endcase
    end
  end

  // Moore decode of every output from the phase register
  assign initDriveLow = (phase == PH_POWERUP) || (phase == PH_CLEAR);
  assign clearMem     = (phase == PH_CLEAR);
  assign loadEn       = (phase == PH_LOAD);
  assign doneOut      = (phase == PH_DONE) || (phase == PH_GTSOFF) || (phase == PH_RUN);
  assign gtsHold      = !((phase == PH_GTSOFF) || (phase == PH_RUN));
  assign gsrHold      = (phase != PH_RUN);
  assign gweHold      = (phase != PH_RUN);

  AST_INIT_HOLDOFF: assert property (@(posedge clk) disable iff (porRst)
    (phase == PH_INITWAIT && !initIn && !progAccept) |=> !loadEn); // R4

  AST_DONE_AFTER_LOAD: assert property (@(posedge clk) disable iff (porRst)
    $rose(doneOut) |-> ($past(loadEn && loadDone) && gtsHold && gsrHold)); // R5

  AST_GTS_AFTER_DONE: assert property (@(posedge clk) disable iff (porRst)
    $fell(gtsHold) |-> ($past(doneOut) && doneOut && gsrHold)); // R6

  AST_GSR_AFTER_GTS: assert property (@(posedge clk) disable iff (porRst)
    $fell(gsrHold) |-> (!gweHold && $past(!gtsHold))); // R7

  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (porRst)
    progAccept |=> (clearMem && initDriveLow && !doneOut && gtsHold && gsrHold && gweHold)); // R10

  AST_STRAY_LOADDONE: assert property (@(posedge clk) disable iff (porRst)
    (!loadEn && !doneOut && loadDone) |=> !doneOut); // R11

endmodule

// File: rtl/cfg_startup_seq.sv
module cfg_startup_seq
  import cfg_seq_pkg::*;
#(
  parameter int POR_CYCLES   = 1000,
  parameter int CLEAR_CYCLES = 256,
  parameter int PROG_MIN     = 4
) (
  input  logic       clk,
  input  logic       porRst,
  input  logic       progReqN,
  input  logic       initIn,
  input  logic [2:0] modeSel,
  input  logic       loadDone,
  output logic       initDriveLow,
  output logic       clearMem,
  output logic       loadEn,
  output logic       scanSelect,
  output logic       doneOut,
  output logic       gtsHold,
  output logic       gsrHold,
  output logic       gweHold
);

  dpCtl_t ctl;
  logic   hitPor;
  logic   hitClear;
  logic   progAccept;

  cfg_seq_dpath #(
    .POR_CYCLES  (POR_CYCLES),
    .CLEAR_CYCLES(CLEAR_CYCLES),
    .PROG_MIN    (PROG_MIN)
  ) dpath_i (
    .clk       (clk),
    .porRst    (porRst),
    .progReqN  (progReqN),
    .modeSel   (modeSel),
    .ctl       (ctl),
    .hitPor    (hitPor),
    .hitClear  (hitClear),
    .progAccept(progAccept),
    .scanSel   (scanSelect)
  );

  cfg_seq_ctrl ctrl_i (
    .clk         (clk),
    .porRst      (porRst),
    .hitPor      (hitPor),
    .hitClear    (hitClear),
    .progAccept  (progAccept),
    .initIn      (initIn),
    .loadDone    (loadDone),
    .ctl         (ctl),
    .initDriveLow(initDriveLow),
    .clearMem    (clearMem),
    .loadEn      (loadEn),
    .doneOut     (doneOut),
    .gtsHold     (gtsHold),
    .gsrHold     (gsrHold),
    .gweHold     (gweHold)
  );

endmodule

// File: tb/cfg_startup_seq_tb_top.sv
module cfg_startup_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int POR_N   = 5;
  localparam int CLEAR_N = 6;
  localparam int PROG_N  = 3;

  logic clk = 1'b0;
  logic porRst = 1'b1;
  logic progReqN = 1'b1;
  logic extHold = 1'b0;
  logic [2:0] modeSel = 3'b000;
  logic loadDone = 1'b0;
  logic initIn;
  logic initDriveLow, clearMem, loadEn, scanSelect, doneOut, gtsHold, gsrHold, gweHold;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // reference model state
  int  mPhase = 0;
  int  mCnt = 0;
  int  mProg = 0;
  bit  mScan = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // open-drain wire: low when the block or the outside agent pulls it
  assign initIn = ~(initDriveLow | extHold);

  cfg_startup_seq #(
    .POR_CYCLES(POR_N), .CLEAR_CYCLES(CLEAR_N), .PROG_MIN(PROG_N)
  ) dut_i (
    .clk(clk), .porRst(porRst), .progReqN(progReqN), .initIn(initIn),
    .modeSel(modeSel), .loadDone(loadDone), .initDriveLow(initDriveLow),
    .clearMem(clearMem), .loadEn(loadEn), .scanSelect(scanSelect),
    .doneOut(doneOut), .gtsHold(gtsHold), .gsrHold(gsrHold), .gweHold(gweHold)
  );

  function automatic bit scanPins(input logic [2:0] m);
    return (m == 3'b101) || (m == 3'b001);
  endfunction

  task automatic chk(input string req, input string name, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, name, act, exp);
    end
  endtask

  task automatic chkInt(input string req, input string name, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, name, act, exp);
    end
  endtask

  task automatic compareAll();
    bit p0 = (mPhase == 0);
    chk(p0 ? "R1" : "R2", "initDriveLow", initDriveLow, mPhase <= 1);
    chk(p0 ? "R1" : "R2", "clearMem", clearMem, mPhase == 1);
    chk(p0 ? "R1" : "R3", "loadEn", loadEn, mPhase == 3);
    chk(p0 ? "R1" : "R8", "scanSelect", scanSelect, mScan);
    chk(p0 ? "R1" : "R5", "doneOut", doneOut, mPhase >= 4);
    chk(p0 ? "R1" : "R6", "gtsHold", gtsHold, mPhase < 5);
    chk(p0 ? "R1" : "R7", "gsrHold", gsrHold, mPhase < 6);
    chk(p0 ? "R1" : "R7", "gweHold", gweHold, mPhase < 6);
  endtask

  // one clock: advance the model from the inputs present before the edge
  task automatic tick();
    bit initNow = !((mPhase <= 1) || extHold);
    bit accept  = (mProg == PROG_N);
    int nPhase = mPhase, nCnt = mCnt, nProg;
    bit nScan = mScan;
    nProg = progReqN ? 0 : ((mProg < PROG_N) ? mProg + 1 : PROG_N);
    if (accept) begin
      nPhase = 1; nCnt = 0;
    end else begin
      case (mPhase)
        0: if (mCnt == POR_N - 1) begin nPhase = 1; nCnt = 0; end else nCnt = mCnt + 1;
        1: if (mCnt == CLEAR_N - 1) begin nPhase = 2; nScan = scanPins(modeSel); end
           else nCnt = mCnt + 1;
        2: if (initNow) nPhase = 3;
        3: if (loadDone) nPhase = 4;
        4: nPhase = 5;
        5: nPhase = 6;
        default: nPhase = 6;
      endcase
    end
    @(posedge clk);
    #1;
    mPhase = nPhase; mCnt = nCnt; mProg = nProg; mScan = nScan;
    compareAll();
  endtask

  initial begin
    int porTicks, clrTicks, guard, burst;
    // reset
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset initDriveLow", initDriveLow, 1'b1);
    chk("R1", "reset doneOut", doneOut, 1'b0);
    chk("R1", "reset holds", gtsHold & gsrHold & gweHold, 1'b1);
    chk("R1", "reset clearMem", clearMem, 1'b0);
    porRst = 1'b0;
    modeSel = 3'b101;
    extHold = 1'b1;
    loadDone = 1'b1;

    // power-up phase length
    porTicks = 0;
    while (!clearMem && porTicks < 50) begin tick(); porTicks++; end
    chkInt("R1", "power-up cycles", porTicks, POR_N);

    // clear phase length, stray loadDone ignored
    clrTicks = 0;
    while (clearMem && clrTicks < 50) begin clrTicks++; tick(); end
    chkInt("R2", "clear cycles", clrTicks, CLEAR_N);
    chk("R11", "stray loadDone ignored", doneOut, 1'b0);
    loadDone = 1'b0;

    // INIT held low from outside
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R4", "loadEn while INIT held", loadEn, 1'b0);
    end
    extHold = 1'b0;
    tick();
    chk("R4", "loadEn after INIT high", loadEn, 1'b1);
    chk("R8", "scan mode 101", scanSelect, 1'b1);
    for (int i = 0; i < 2; i++) begin
      tick();
      chk("R3", "no done while loading", doneOut, 1'b0);
    end
    loadDone = 1'b1;
    tick();
    chk("R5", "done rises", doneOut, 1'b1);
    chk("R5", "gts still held", gtsHold, 1'b1);
    loadDone = 1'b0;
    tick();
    chk("R6", "gts released", gtsHold, 1'b0);
    chk("R6", "gsr held", gsrHold, 1'b1);
    tick();
    chk("R7", "gsr released", gsrHold, 1'b0);
    chk("R7", "gwe released", gweHold, 1'b0);

    // short program pulse
    progReqN = 1'b0;
    for (int i = 0; i < PROG_N - 1; i++) tick();
    progReqN = 1'b1;
    for (int i = 0; i < 3; i++) tick();
    chk("R9", "short pulse ignored done", doneOut, 1'b1);
    chk("R9", "short pulse ignored gsr", gsrHold, 1'b0);

    // full-width program pulse aborts from run
    modeSel = 3'b110;
    progReqN = 1'b0;
    for (int i = 0; i < PROG_N; i++) tick();
    chk("R9", "not yet accepted", doneOut, 1'b1);
    tick();
    chk("R10", "abort clearMem", clearMem, 1'b1);
    chk("R10", "abort doneOut", doneOut, 1'b0);
    chk("R10", "abort holds", gtsHold & gsrHold & gweHold, 1'b1);
    for (int i = 0; i < 3; i++) tick();
    chk("R10", "clear held while request", clearMem, 1'b1);
    progReqN = 1'b1;
    guard = 0;
    while (!loadEn && guard < 50) begin tick(); guard++; end
    chk("R3", "reached load", loadEn, 1'b1);
    chk("R8", "scan mode 110", scanSelect, 1'b0);

    // constrained random
    void'($urandom(32'h5eed_0c0f));
    burst = 0;
    for (int i = 0; i < 4000; i++) begin
      if (burst > 0) begin
        progReqN = 1'b0; burst--;
      end else begin
        progReqN = 1'b1;
        if ($urandom_range(0, 79) == 0) burst = $urandom_range(1, PROG_N + 3);
      end
      extHold  = ($urandom_range(0, 3) == 0);
      loadDone = ($urandom_range(0, 4) < 2);
      modeSel  = 3'($urandom_range(0, 7));
      tick();
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule